// File: doc/BRIEF.md
# SPI Serial Memory Slave Front End

This block is the serial side of a small byte-wide nonvolatile memory reached over a four-wire SPI link in mode 0. A fast system clock oversamples the link pins through a synchronizer. The block recognises a one-byte command that opens each selection and then runs the address and data phases against an internal byte array. It returns serial data together with an output enable, so that a pad can tri-state the line.

A status register holds a busy flag, a write-enable latch and a protect-enable bit. A timed internal write cycle follows every accepted write. While that cycle runs, the only command that works is a status read. A hold input can pause a transfer in the middle of a byte. A write-protect input can block status writes, but only when the protect-enable bit is set.

Top module: `spiee_slave`

## Requirements
- R1: Reset leaves the output enable low, the status at 0x00 and every array byte at 0x00. Every byte travels MSB first. SI is taken on the SCK rising edge and SO changes on the SCK falling edge.
- R2: The status byte has busy in bit 0, the write-enable latch in bit 1 and protect-enable in bit 7, with all other bits reading 0. Command 0x06 sets the latch and 0x04 clears it. Command 0x05 returns the status byte and repeats it for as long as clocks continue.
- R3: Command 0x03 followed by ADDR_BYTES address bytes (MSB first, low ADDR_W bits used) streams array bytes from that address. The address increments after each byte and wraps from the last location to 0.
- R4: Command 0x02 followed by the address and data bytes buffers the data within a PAGE-byte aligned page, and the in-page pointer wraps. The page is committed only if the write-enable latch is set and CS_n rises on a byte boundary. A deselect in the middle of a byte, or a write without the latch set, changes nothing.
- R5: An accepted write runs an internal cycle of WC_CYCLES clocks with busy set, and the latch clears when the cycle ends. During the cycle every command except 0x05 is treated as invalid.
- R6: An unrecognised command byte locks the interface: later SI bits are ignored and SO stays undriven until CS_n is next deselected and selected.
- R7: While CS_n is high, SCK and SI activity has no effect and SO is undriven.
- R8: HOLD_n low while SCK is low pauses the transfer and keeps its bit and byte progress. SO is undriven and SCK edges are ignored during the pause. HOLD_n high while SCK is low resumes the transfer.
- R9: Command 0x01 followed by one byte writes protect-enable from bit 7. The write is inhibited when WP_n is low and protect-enable is 1. When protect-enable is 0, WP_n has no effect.
- R10: If WP_n goes low during a status write, with protect-enable set, before CS_n rises, the write is aborted even if WP_n returns high. Once the internal cycle has started, WP_n has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the link |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause request |
| wp_n | input | 1 | Active-low write protect for the status register |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the tri-state SO pad |

## Verification
The bench builds the block with a 4-bit address and a single address byte, which gives a 16-byte array. It uses 4-byte pages and an internal cycle of 400 clocks. With this small array, writing every location and reading it back in one burst is practical, and the burst crosses the wrap from location 15 back to 0. The short cycle leaves time to read the status, and to try a locked-out read, while the cycle is still running. The bench also runs every write-protect combination, a hold in the middle of a byte, deselects in the middle of a byte and invalid commands.

// File: rtl/spiee_pkg.sv
package spiee_pkg;
   localparam logic [7:0] OP_SETWEL = 8'h06;
   localparam logic [7:0] OP_CLRWEL = 8'h04;
   localparam logic [7:0] OP_RDSTAT = 8'h05;
   localparam logic [7:0] OP_WRSTAT = 8'h01;
   localparam logic [7:0] OP_READ   = 8'h03;
   localparam logic [7:0] OP_WRITE  = 8'h02;

   localparam int SB_BUSY = 0;
   localparam int SB_WEL  = 1;
   localparam int SB_WPEN = 7;

   typedef enum logic [2:0] {
      S_OP, S_ADDR, S_RDATA, S_WDATA, S_RDSR, S_WRSR, S_LOCK, S_END
   } phase_t;
endpackage

// File: rtl/spiee_sync.sv
module spiee_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] st;

   initial begin : elab_checks
      assert (STAGES >= 1) else $error("spiee_sync: STAGES must be at least 1");
   end

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st <= INIT;
            else        st <= d;
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st <= {STAGES{INIT}};
            else        st <= {st[STAGES-2:0], d};
      end
   endgenerate

   assign q = st[STAGES-1];
endmodule

// File: rtl/spiee_wtimer.sv
module spiee_wtimer #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(CYCLES + 1);
   logic [CW-1:0] cnt;

   initial begin : elab_checks
      assert (CYCLES >= 2) else $error("spiee_wtimer: CYCLES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= CW'(CYCLES);
      else if (cnt != '0)  cnt <= cnt - 1'b1;

   assign busy = (cnt != '0);
   assign done = (cnt == CW'(1));

   // R5: a new cycle is only launched when idle
   p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
   // R5: the final count leaves the timer idle
   p_done_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
endmodule

// File: rtl/spiee_slave.sv
module spiee_slave
   import spiee_pkg::*;
#(
   parameter int ADDR_W      = 5,
   parameter int ADDR_BYTES  = 2,
   parameter int PAGE        = 8,
   parameter int WC_CYCLES   = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic si,
   input  logic hold_n,
   input  logic wp_n,
   output logic so,
   output logic so_oe
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int PW    = $clog2(PAGE);
   localparam int AC_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
   localparam logic [ADDR_W-1:0] PMASK = ADDR_W'(PAGE - 1);

   initial begin : elab_checks
      assert (ADDR_W >= 1 && ADDR_W <= 8 * ADDR_BYTES)
         else $error("spiee_slave: ADDR_W must fit in ADDR_BYTES");
      assert (PAGE >= 2 && (1 << PW) == PAGE && PAGE <= DEPTH)
         else $error("spiee_slave: PAGE must be a power of two within the array");
      assert (SYNC_STAGES >= 1) else $error("spiee_slave: SYNC_STAGES too small");
   end

   // ---------------- pin synchronisation and edge detection
   logic [4:0] pins_s;
   logic sck_s, cs_s, hold_s, wp_s, si_s;
   spiee_sync #(.W(5), .STAGES(SYNC_STAGES), .INIT(5'b01110)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({si, wp_n, hold_n, cs_n, sck}), .q(pins_s));
   assign sck_s  = pins_s[0];
   assign cs_s   = pins_s[1];
   assign hold_s = pins_s[2];
   assign wp_s   = pins_s[3];
   assign si_s   = pins_s[4];

   logic sck_d, cs_d, held;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         sck_d <= 1'b0; cs_d <= 1'b1; held <= 1'b0;
      end else begin
         sck_d <= sck_s;
         cs_d  <= cs_s;
         if (cs_s)        held <= 1'b0;
         else if (!sck_s) held <= !hold_s;
      end

   // ---------------- write cycle timer
   logic wr_start, busy, wc_done;
   spiee_wtimer #(.CYCLES(WC_CYCLES)) u_wtimer (
      .clk(clk), .rst_n(rst_n), .start(wr_start), .busy(busy), .done(wc_done));

   // ---------------- transaction state
   phase_t            phase;
   logic [2:0]        bcnt;
   logic [6:0]        shin;
   logic [AC_W-1:0]   acnt;
   logic [ADDR_W-1:0] addr_acc, ptr;
   logic              op_rd, ld_pend, drv, oe_q;
   logic [7:0]        oreg, nxt;
   logic              wel, wpen, sr_new, sr_got, wp_abort;
   logic [7:0]        mem  [DEPTH];
   logic [7:0]        pbuf [PAGE];
   logic [PAGE-1:0]   pval;

   logic              en, sck_rise, sck_fall, cs_rise, commit_ok, mem_go, sr_go;
   logic [7:0]        byte_in, stat;
   logic [ADDR_W-1:0] acat, page_base;

   always_comb begin
      en        = !cs_s && !held;
      sck_rise  = en && sck_s && !sck_d;
      sck_fall  = en && !sck_s && sck_d;
      cs_rise   = cs_s && !cs_d;
      byte_in   = {shin, si_s};
      acat      = ADDR_W'({addr_acc, byte_in});
      page_base = ptr & ~PMASK;
      commit_ok = cs_rise && (bcnt == 3'd0) && wel && !busy;
      mem_go    = commit_ok && (phase == S_WDATA) && (|pval);
      sr_go     = commit_ok && sr_got && !wp_abort && !(wpen && !wp_s);
      wr_start  = mem_go || sr_go;
      stat          = '0;
      stat[SB_BUSY] = busy;
      stat[SB_WEL]  = wel;
      stat[SB_WPEN] = wpen;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         phase <= S_OP; bcnt <= '0; shin <= '0; acnt <= '0;
         addr_acc <= '0; ptr <= '0; op_rd <= 1'b0; ld_pend <= 1'b0; drv <= 1'b0;
         oreg <= '0; nxt <= '0; wel <= 1'b0; wpen <= 1'b0;
         sr_new <= 1'b0; sr_got <= 1'b0; wp_abort <= 1'b0; pval <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         for (int i = 0; i < PAGE; i++)  pbuf[i] <= '0;
      end else begin
         if (wc_done) wel  <= 1'b0;
         if (sr_go)   wpen <= sr_new;
         if (mem_go)
            for (int i = 0; i < PAGE; i++)
               if (pval[i]) mem[page_base | ADDR_W'(i)] <= pbuf[i];

         if (cs_s) begin
            phase <= S_OP; bcnt <= '0; acnt <= '0; ld_pend <= 1'b0;
            drv <= 1'b0; sr_got <= 1'b0; wp_abort <= 1'b0; pval <= '0;
         end else begin
            if ((phase == S_WRSR || sr_got) && wpen && !wp_s) wp_abort <= 1'b1;

            if (sck_fall) begin
               if (ld_pend) begin
                  oreg <= nxt; ld_pend <= 1'b0; drv <= 1'b1;
               end else begin
                  oreg <= {oreg[6:0], 1'b0};
               end
            end

            if (sck_rise) begin
               shin <= byte_in[6:0];
               bcnt <= bcnt + 1'b1;
               if (bcnt == 3'd7) begin
                  case (phase)
                     S_OP: begin
                        if (busy) begin
                           phase <= (byte_in == OP_RDSTAT) ? S_RDSR : S_LOCK;
                           nxt <= stat; ld_pend <= (byte_in == OP_RDSTAT);
                        end else begin
                           case (byte_in)
                              OP_SETWEL: begin wel <= 1'b1; phase <= S_END; end
                              OP_CLRWEL: begin wel <= 1'b0; phase <= S_END; end
                              OP_RDSTAT: begin phase <= S_RDSR; nxt <= stat; ld_pend <= 1'b1; end
                              OP_WRSTAT: phase <= S_WRSR;
                              OP_READ:   begin phase <= S_ADDR; op_rd <= 1'b1; end
                              OP_WRITE:  begin phase <= S_ADDR; op_rd <= 1'b0; end
                              default:   phase <= S_LOCK;
                           endcase
                        end
                     end
                     S_ADDR: begin
                        addr_acc <= acat;
                        if (acnt == AC_W'(ADDR_BYTES - 1)) begin
                           if (op_rd) begin
                              nxt <= mem[acat]; ptr <= acat + 1'b1;
                              ld_pend <= 1'b1; phase <= S_RDATA;
                           end else begin
                              ptr <= acat; phase <= S_WDATA;
                           end
                        end else begin
                           acnt <= acnt + 1'b1;
                        end
                     end
                     S_RDATA: begin
                        nxt <= mem[ptr]; ptr <= ptr + 1'b1; ld_pend <= 1'b1;
                     end
                     S_RDSR: begin
                        nxt <= stat; ld_pend <= 1'b1;
                     end
                     S_WDATA: begin
                        pbuf[ptr[PW-1:0]] <= byte_in;
                        pval[ptr[PW-1:0]] <= 1'b1;
                        ptr <= page_base | ((ptr + 1'b1) & PMASK);
                     end
                     S_WRSR: begin
                        sr_new <= byte_in[SB_WPEN]; sr_got <= 1'b1; phase <= S_END;
                     end
                     default: ;
                  endcase
               end
            end
         end
      end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= !cs_s && !held && drv && (phase == S_RDATA || phase == S_RDSR);

   assign so    = oreg[7];
   assign so_oe = oe_q;

   // R7: deselect releases the output
   p_cs_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !so_oe);
   // R8: a paused transfer never drives SO
   p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      held |=> !so_oe);
   // R6: locked interface stays silent
   p_lock_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == S_LOCK) |=> !so_oe);
   // R5: the latch is gone once the cycle ends
   p_wel_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !wel);
   // R4: a write cycle only starts from a set latch
   p_commit_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wel));
   // R9: protect-enable only changes as a write cycle begins
   p_wpen_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wpen) |-> $rose(busy));
endmodule

// File: tb/spiee_slave_bench.sv
module spiee_slave_bench;
   localparam int AW = 4, AB = 1, PG = 4, WC = 400, HALF = 8, DEPTH = 16;

   logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
   logic hold_n = 1'b1, wp_n = 1'b1;
   logic so, so_oe;
   int   total = 0, bad = 0, oe_cnt = 0;

   always #5 clk = ~clk;
   always @(negedge clk) if (so_oe) oe_cnt <= oe_cnt + 1;

   spiee_slave #(.ADDR_W(AW), .ADDR_BYTES(AB), .PAGE(PG), .WC_CYCLES(WC),
                 .SYNC_STAGES(2)) u_spiee_slave (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
      .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe));

   function automatic logic [7:0] val(int a);
      return 8'(a * 29 + 7);
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic ck(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xbits(input logic [7:0] d, input int n, output logic [7:0] q);
      q = '0;
      for (int i = 7; i >= 8 - n; i--) begin
         si = d[i];
         ck(HALF);
         q[i] = so_oe ? so : 1'b0;
         sck = 1'b1;
         ck(HALF);
         sck = 1'b0;
      end
   endtask

   task automatic xb(input logic [7:0] d, output logic [7:0] q);
      xbits(d, 8, q);
   endtask

   task automatic sel();
      cs_n = 1'b0; ck(HALF);
   endtask

   task automatic desel();
      ck(HALF); cs_n = 1'b1; ck(2 * HALF);
   endtask

   task automatic op1(input logic [7:0] d);
      logic [7:0] q;
      sel(); xb(d, q); desel();
   endtask

   task automatic rdsr(output logic [7:0] s);
      logic [7:0] q;
      sel(); xb(8'h05, q); xb(8'h00, s); desel();
   endtask

   task automatic rd1(input int a, output logic [7:0] v);
      logic [7:0] q;
      sel(); xb(8'h03, q); xb(8'(a), q); xb(8'h00, v); desel();
   endtask

   task automatic wrsr(input logic [7:0] v);
      logic [7:0] q;
      sel(); xb(8'h01, q); xb(v, q); desel();
   endtask

   initial begin : main
      logic [7:0] q, s;
      int snap;
      ck(10); rst_n = 1'b1; ck(5);

      // R1 reset state
      chk("R1 oe after reset", {7'd0, so_oe}, 8'h00);
      rdsr(s); chk("R1 status after reset", s, 8'h00);
      rd1(0, q); chk("R1 array after reset", q, 8'h00);

      // R2 latch set / clear
      op1(8'h06); rdsr(s); chk("R2 latch set", s, 8'h02);
      op1(8'h04); rdsr(s); chk("R2 latch clear", s, 8'h00);

      // R4 write with latch clear is dropped
      sel(); xb(8'h02, q); xb(8'h00, q); xb(8'h5A, q); desel();
      rdsr(s); chk("R4 no cycle without latch", s, 8'h00);
      rd1(0, q); chk("R4 no write without latch", q, 8'h00);

      // R4/R5 full array write, page by page
      for (int p = 0; p < DEPTH / PG; p++) begin
         op1(8'h06);
         sel(); xb(8'h02, q); xb(8'(p * PG), q);
         for (int i = 0; i < PG; i++) xb(val(p * PG + i), q);
         desel();
         if (p == 0) begin
            rdsr(s); chk("R5 busy and latch during cycle", s, 8'h03);
         end
         if (p == 1) begin
            snap = oe_cnt;
            sel(); xb(8'h03, q); xb(8'h00, q); xb(8'h00, q); desel();
            chk("R5 read locked out while busy", 8'(oe_cnt - snap), 8'h00);
         end
         ck(WC + 30);
         rdsr(s); chk("R5 idle and latch cleared after cycle", s, 8'h00);
      end

      // R3 burst read across the wrap, R1 MSB-first data
      sel(); xb(8'h03, q); xb(8'h00, q);
      for (int i = 0; i < DEPTH + 4; i++) begin
         xb(8'h00, q); chk($sformatf("R3 burst byte %0d", i), q, val(i % DEPTH));
      end
      desel();
      sel(); xb(8'h03, q); xb(8'd14, q);
      for (int i = 0; i < 4; i++) begin
         xb(8'h00, q); chk("R3 wrap from high start", q, val((14 + i) % DEPTH));
      end
      desel();

      // R4 in-page pointer wrap
      op1(8'h06);
      sel(); xb(8'h02, q); xb(8'd8, q);
      xb(8'h11, q); xb(8'h22, q); xb(8'h33, q); xb(8'h44, q); xb(8'h55, q);
      desel(); ck(WC + 30);
      rd1(8, q);  chk("R4 page wrap overwrite", q, 8'h55);
      rd1(9, q);  chk("R4 page byte 1", q, 8'h22);
      rd1(11, q); chk("R4 page byte 3", q, 8'h44);
      rd1(12, q); chk("R4 next page untouched", q, val(12));

      // R4 deselect mid-byte cancels the write
      op1(8'h06);
      sel(); xb(8'h02, q); xb(8'd2, q); xb(8'hAA, q); xbits(8'hFF, 3, q); desel();
      rdsr(s); chk("R4 mid-byte deselect no cycle", s, 8'h02);
      rd1(2, q); chk("R4 mid-byte deselect data kept", q, val(2));
      op1(8'h04);

      // R6 invalid command lockout
      snap = oe_cnt;
      sel(); xb(8'hA5, q); xb(8'h05, q); xb(8'h00, q); desel();
      chk("R6 no drive after invalid command", 8'(oe_cnt - snap), 8'h00);
      rdsr(s); chk("R6 decoding restarts on next select", s, 8'h00);

      // R7 activity while deselected
      snap = oe_cnt;
      for (int i = 0; i < 12; i++) begin
         si = i[0]; ck(HALF); sck = 1'b1; ck(HALF); sck = 1'b0;
      end
      chk("R7 no drive while deselected", 8'(oe_cnt - snap), 8'h00);
      rdsr(s); chk("R7 bits ignored while deselected", s, 8'h00);

      // R8 hold mid-byte during a read
      sel(); xb(8'h03, q); xb(8'h00, q);
      q = '0;
      for (int i = 7; i >= 0; i--) begin
         si = 1'b0; ck(HALF);
         if (i == 3) begin
            hold_n = 1'b0; ck(HALF);
            snap = oe_cnt;
            for (int k = 0; k < 4; k++) begin
               sck = 1'b1; si = k[0]; ck(HALF); sck = 1'b0; ck(HALF);
            end
            chk("R8 no drive while held", 8'(oe_cnt - snap), 8'h00);
            si = 1'b0; hold_n = 1'b1; ck(HALF);
         end
         q[i] = so_oe ? so : 1'b0;
         sck = 1'b1; ck(HALF); sck = 1'b0;
      end
      chk("R8 byte intact across hold", q, val(0));
      xb(8'h00, q); chk("R8 following byte after hold", q, val(1));
      desel();

      // R9 protect-enable with WP_n low
      wp_n = 1'b0;
      op1(8'h06); wrsr(8'h80); ck(WC + 30);
      rdsr(s); chk("R9 status write with protect-enable clear", s, 8'h80);
      op1(8'h06); wrsr(8'h00); ck(40);
      rdsr(s); chk("R9 status write inhibited", s, 8'h82);

      // R10 WP_n pulse during the write aborts it
      wp_n = 1'b1;
      sel(); xb(8'h01, q); xb(8'h00, q);
      wp_n = 1'b0; ck(HALF); wp_n = 1'b1; ck(HALF);
      desel();
      rdsr(s); chk("R10 status write aborted", s, 8'h82);

      // R10 WP_n low after the cycle started
      wrsr(8'h00); ck(4); wp_n = 1'b0;
      rdsr(s); chk("R10 cycle running", s, 8'h03);
      ck(WC + 30);
      rdsr(s); chk("R10 write completed despite WP_n", s, 8'h00);
      wp_n = 1'b1;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule